// File: doc/BRIEF.md
# Boot-Time ROM-to-SRAM Copier

This block owns the memory bus for a short interval after power-up. While the processor is held in reset with its bus drivers switched off, a counter built from two cascaded stages walks every address of a slow ROM. At each address the ROM byte is read and then written into a fast SRAM at the same location. The processor never executes from the slow part and needs no boot firmware to relocate itself.

Each byte takes two clock cycles. In the read phase the address is on the bus and the ROM output is enabled. In the write phase the captured byte is presented with the SRAM write strobe high. After the final location has been written, the counter stops driving the address bus and both memory enables drop. The processor bus enable then rises. Processor reset is held for a further fixed number of clocks so that the bus is quiet before the processor starts. From then on only the processor addresses the SRAM, and the ROM stays deselected until the next reset.

Top module: `boot_copier`

## Requirements
- R1: While `rst_n` is low, `cpu_rst_n`, `cpu_be`, `copy_done` and `sram_we` are 0, and `addr_oe` is 1 with `mem_addr` equal to 0.
- R2: Each copied byte takes a read cycle (`rom_oe` high, `sram_we` low) followed by a write cycle (`sram_we` high). The address is the same in both cycles, and `sram_wdata` equals the ROM byte at that address.
- R3: Write strobes visit the addresses 0 to COPY_LEN-1 in ascending order, one step at a time, each exactly once. The order holds across the carry from the low counter stage into the high stage.
- R4: In the cycle after the last write, `addr_oe`, `rom_oe`, `sram_ce` and `sram_we` are 0, and `cpu_be` and `copy_done` are 1, with `cpu_rst_n` still 0.
- R5: `cpu_rst_n` stays 0 for exactly HOLD_CLKS clock cycles (default 2) after `cpu_be` rises, and then goes to 1.
- R6: Once `copy_done` is 1, it stays 1 until reset. From then on `rom_oe`, `sram_we` and `addr_oe` stay 0.
- R7: When the copy is complete, every SRAM location 0 to COPY_LEN-1 holds the ROM byte at the same address.
- R8: Asserting `rst_n` at any time, including mid-copy, immediately returns the outputs to the R1 state. After release the copy restarts from address 0.
- R9: `cpu_be` and `addr_oe` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| rom_data | input | DATA_W | Byte returned by the ROM |
| mem_addr | output | ADDR_W | Shared address bus value driven by the copier |
| addr_oe | output | 1 | Copier drives the address bus |
| rom_oe | output | 1 | ROM chip/output enable |
| sram_ce | output | 1 | SRAM chip enable for the copy |
| sram_we | output | 1 | SRAM write strobe |
| sram_wdata | output | DATA_W | Byte presented to the SRAM during a write |
| cpu_be | output | 1 | Processor bus enable |
| cpu_rst_n | output | 1 | Processor reset, active low |
| copy_done | output | 1 | Copy has reached terminal count |

## Verification
The hardest situation to reach from the ports is a reset that arrives partway through a copy. At that moment the counter holds a nonzero value and the low stage may already have carried into the high stage. The bench watches the write strobes until a set number of bytes has been written, then pulls reset between clock edges and checks that the outputs fall back at once. It then lets a complete second copy run and checks that it starts again at address 0. The carry between the two counter stages is covered by checking, on every strobe, that the address is exactly one more than the last.

// File: rtl/boot_copier_pkg.sv
package boot_copier_pkg;

  // Sequencer phases; READ/WRITE alternate per byte, HOLD and RUN follow.
  typedef enum logic [1:0] {
    PH_READ  = 2'd0,
    PH_WRITE = 2'd1,
    PH_HOLD  = 2'd2,
    PH_RUN   = 2'd3
  } copy_phase_e;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/boot_count_stage.sv
module boot_count_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cin,
  output logic [W-1:0] q,
  output logic         cout
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (cin) begin
      q_d = q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

  assign cout = cin & (&q);

  // R3: an enabled stage advances by exactly one (with wrap)
  assert_stage_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cin |=> (q == W'($past(q) + 1'b1)));

  // R3: a disabled stage holds its value
  assert_stage_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cin |=> $stable(q));

endmodule

// File: rtl/boot_addr_counter.sv
module boot_addr_counter #(
  parameter int ADDR_W = 15,
  parameter int LO_W   = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);

  localparam int HI_W = ADDR_W - LO_W;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_carry;
  logic            hi_carry;

  boot_count_stage #(.W(LO_W)) u_lo (
    .clk  (clk),
    .rst_n(rst_n),
    .cin  (step),
    .q    (lo_q),
    .cout (lo_carry)
  );

  boot_count_stage #(.W(HI_W)) u_hi (
    .clk  (clk),
    .rst_n(rst_n),
    .cin  (lo_carry),
    .q    (hi_q),
    .cout (hi_carry)
  );

  assign addr = {hi_q, lo_q};

  // R3: the joined count moves by one per step, including across the stage boundary
  assert_joined_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hi_carry) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_copier_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int COPY_LEN  = 1 << ADDR_W,
  parameter int HOLD_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              step,
  output copy_phase_e       phase
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(COPY_LEN - 1);
  localparam int                HOLD_W    = $clog2(HOLD_CLKS + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CLKS - 1);

  copy_phase_e     phase_d;
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_d;
  logic            hold_en;
  logic            at_last;

  assign at_last = (addr == LAST_ADDR);
  assign hold_en = (phase == PH_HOLD);

  always_comb begin
    phase_d = phase;
    step    = 1'b0;
    unique case (phase)
      PH_READ:  phase_d = PH_WRITE;
      PH_WRITE: begin
        if (at_last) begin
          phase_d = PH_HOLD;
        end else begin
          phase_d = PH_READ;
          step    = 1'b1;
        end
      end
      PH_HOLD:  if (hold_q == HOLD_LAST) phase_d = PH_RUN;
      PH_RUN:   phase_d = PH_RUN;
      default:  phase_d = PH_READ;
    endcase
  end

  always_comb begin
    hold_d = hold_q;
    if (hold_en) begin
      hold_d = hold_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_READ;
      hold_q <= '0;
    end else begin
      phase  <= phase_d;
      hold_q <= hold_d;
    end
  end

  // R4: writing the final address hands over to the hold phase
  assert_last_to_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WRITE && at_last) |=> (phase == PH_HOLD));

  // R2: a write phase is always preceded by a read phase
  assert_read_before_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WRITE) |-> ($past(phase) == PH_READ));

  // R6: the run phase is terminal
  assert_run_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RUN) |=> (phase == PH_RUN));

endmodule

// File: rtl/boot_copier.sv
module boot_copier
  import boot_copier_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int COPY_LEN  = 1 << ADDR_W,
  parameter int HOLD_CLKS = 2,
  parameter int LO_W      = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rom_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              addr_oe,
  output logic              rom_oe,
  output logic              sram_ce,
  output logic              sram_we,
  output logic [DATA_W-1:0] sram_wdata,
  output logic              cpu_be,
  output logic              cpu_rst_n,
  output logic              copy_done
);

  logic              srst_n;
  logic              step;
  logic [ADDR_W-1:0] cnt_addr;
  copy_phase_e       phase;
  logic              copying;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] data_d;
  logic              capture_en;

  // Asynchronous assertion, synchronous release.
  boot_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(srst_n)
  );

  boot_addr_counter #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_cnt (
    .clk  (clk),
    .rst_n(srst_n),
    .step (step),
    .addr (cnt_addr)
  );

  boot_seq_fsm #(
    .ADDR_W   (ADDR_W),
    .COPY_LEN (COPY_LEN),
    .HOLD_CLKS(HOLD_CLKS)
  ) u_fsm (
    .clk  (clk),
    .rst_n(srst_n),
    .addr (cnt_addr),
    .step (step),
    .phase(phase)
  );

  // Byte latched at the end of the read phase, presented during the write.
  assign capture_en = (phase == PH_READ);

  always_comb begin
    data_d = data_q;
    if (capture_en) begin
      data_d = rom_data;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

  assign copying    = (phase == PH_READ) || (phase == PH_WRITE);
  assign addr_oe    = copying;
  assign mem_addr   = copying ? cnt_addr : '0;
  assign rom_oe     = copying;
  assign sram_ce    = copying;
  assign sram_we    = (phase == PH_WRITE);
  assign sram_wdata = data_q;
  assign cpu_be     = (phase == PH_HOLD) || (phase == PH_RUN);
  assign cpu_rst_n  = (phase == PH_RUN);
  assign copy_done  = cpu_be;

  // R9: the copier and the processor never own the bus together
  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !(cpu_be && addr_oe));

  // R2: the write uses the address that was read in the previous cycle
  assert_write_addr_held_R2: assert property (@(posedge clk) disable iff (!srst_n)
    sram_we |-> (mem_addr == $past(mem_addr)));

  // R5: processor reset releases only after two cycles of bus enable
  assert_reset_after_be_R5: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(cpu_rst_n) |-> ($past(cpu_be, 1) && $past(cpu_be, 2)));

  // R6: once done, the ROM and copy strobes stay off
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!srst_n)
    copy_done |=> (copy_done && !rom_oe && !sram_we && !addr_oe));

endmodule

// File: tb/boot_copier_test.sv
module boot_copier_test;

  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 8;
  localparam int COPY_LEN  = 1 << ADDR_W;
  localparam int HOLD_CLKS = 2;
  localparam int LO_W      = 6;

  // Probe table: address to inspect after a copy, with a tag for the row.
  localparam int NPROBE = 8;
  localparam int PROBE_ADDR [NPROBE] = '{0, 1, 62, 63, 64, 65, 2047, 4095};

  logic              clk = 1'b0;
  logic              rst_n;
  logic [DATA_W-1:0] rom_data;
  logic [ADDR_W-1:0] mem_addr;
  logic              addr_oe, rom_oe, sram_ce, sram_we, cpu_be, cpu_rst_n, copy_done;
  logic [DATA_W-1:0] sram_wdata;

  int checks = 0;
  int fails  = 0;
  int mon_checks = 0;
  int mon_fails  = 0;
  int wr_cnt = 0;
  int exp_next = 0;
  logic [DATA_W-1:0] sram_mem [COPY_LEN];

  always #2.5 clk = ~clk;

  boot_copier #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COPY_LEN(COPY_LEN),
    .HOLD_CLKS(HOLD_CLKS), .LO_W(LO_W)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rom_data(rom_data), .mem_addr(mem_addr),
    .addr_oe(addr_oe), .rom_oe(rom_oe), .sram_ce(sram_ce), .sram_we(sram_we),
    .sram_wdata(sram_wdata), .cpu_be(cpu_be), .cpu_rst_n(cpu_rst_n),
    .copy_done(copy_done)
  );

  function automatic logic [DATA_W-1:0] rom_fn(int a);
    return DATA_W'((a * 29) ^ (a >> 5) ^ 8'hA5);
  endfunction

  // Behavioural ROM and SRAM.
  always_comb rom_data = rom_oe ? rom_fn(int'(mem_addr)) : '0;

  always @(posedge clk) begin
    if (sram_ce && sram_we) sram_mem[mem_addr] <= sram_wdata;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Per-cycle monitor for R2, R3, R6, R9.
  always @(negedge clk) begin
    if (!rst_n) begin
      exp_next = 0;
      wr_cnt   = 0;
    end else begin
      mon_checks++;
      if (addr_oe && cpu_be) begin
        mon_fails++;
        $display("FAIL R9 bus contention actual=1 expected=0");
      end
      if (copy_done && (rom_oe || sram_we || addr_oe)) begin
        mon_fails++;
        $display("FAIL R6 strobe after done actual=%0d expected=0",
                 {rom_oe, sram_we, addr_oe});
      end
      if (sram_we) begin
        mon_checks++;
        if (int'(mem_addr) != exp_next) begin
          mon_fails++;
          $display("FAIL R3 write address actual=%0d expected=%0d", mem_addr, exp_next);
        end
        if (sram_wdata != rom_fn(int'(mem_addr))) begin
          mon_fails++;
          $display("FAIL R2 write data actual=%0d expected=%0d",
                   sram_wdata, rom_fn(int'(mem_addr)));
        end
        exp_next = int'(mem_addr) + 1;
        wr_cnt++;
      end
    end
  end

  task automatic clear_sram();
    for (int i = 0; i < COPY_LEN; i++) sram_mem[i] = '0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!copy_done && n < 3 * COPY_LEN) begin
      @(negedge clk);
      n++;
    end
    chk(copy_done == 1'b1, req, "copy_done reached", copy_done, 1);
  endtask

  task automatic check_reset_state(string req);
    chk(cpu_rst_n == 1'b0, req, "cpu_rst_n in reset", cpu_rst_n, 0);
    chk(cpu_be == 1'b0, req, "cpu_be in reset", cpu_be, 0);
    chk(copy_done == 1'b0, req, "copy_done in reset", copy_done, 0);
    chk(sram_we == 1'b0, req, "sram_we in reset", sram_we, 0);
    chk(addr_oe == 1'b1, req, "addr_oe in reset", addr_oe, 1);
    chk(mem_addr == '0, req, "mem_addr in reset", int'(mem_addr), 0);
  endtask

  task automatic check_full_image(string req);
    int bad = 0;
    int first_bad = -1;
    for (int i = 0; i < COPY_LEN; i++) begin
      if (sram_mem[i] != rom_fn(i)) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    end
    chk(bad == 0, req, "mismatching SRAM bytes (first bad addr in log)", bad, 0);
    if (bad != 0) $display("  first mismatch at address %0d", first_bad);
  endtask

  initial begin
    rst_n = 1'b0;
    clear_sram();
    repeat (3) @(negedge clk);
    check_reset_state("R1");

    // Pass 1: full copy.
    rst_n = 1'b1;
    wait_done("R4");
    chk(addr_oe == 1'b0, "R4", "addr_oe after last write", addr_oe, 0);
    chk(rom_oe == 1'b0, "R4", "rom_oe after last write", rom_oe, 0);
    chk(sram_ce == 1'b0, "R4", "sram_ce after last write", sram_ce, 0);
    chk(sram_we == 1'b0, "R4", "sram_we after last write", sram_we, 0);
    chk(cpu_be == 1'b1, "R4", "cpu_be after last write", cpu_be, 1);
    chk(cpu_rst_n == 1'b0, "R4", "cpu_rst_n after last write", cpu_rst_n, 0);
    chk(wr_cnt == COPY_LEN, "R3", "write strobe count", wr_cnt, COPY_LEN);

    // R5: count cycles of bus enable with reset still held.
    begin
      int held = 0;
      while (cpu_be && !cpu_rst_n && held < 20) begin
        held++;
        @(negedge clk);
      end
      chk(held == HOLD_CLKS, "R5", "cycles of reset after bus enable", held, HOLD_CLKS);
      chk(cpu_rst_n == 1'b1, "R5", "cpu_rst_n released", cpu_rst_n, 1);
    end

    // R6: long run phase stays quiet.
    repeat (40) @(negedge clk);
    chk(copy_done == 1'b1 && cpu_rst_n == 1'b1, "R6", "done/run held",
        {copy_done, cpu_rst_n}, 3);
    chk(rom_oe == 1'b0, "R6", "rom_oe in run", rom_oe, 0);

    // R7: probe table, then a full scan.
    for (int p = 0; p < NPROBE; p++) begin
      chk(sram_mem[PROBE_ADDR[p]] == rom_fn(PROBE_ADDR[p]), "R7",
          $sformatf("probe addr %0d", PROBE_ADDR[p]),
          sram_mem[PROBE_ADDR[p]], rom_fn(PROBE_ADDR[p]));
    end
    check_full_image("R7");

    // Reset after completion takes the bus back from the processor (R8).
    #1.2 rst_n = 1'b0;
    #1;
    check_reset_state("R8");
    clear_sram();
    @(negedge clk);
    rst_n = 1'b1;

    // Pass 2: interrupted partway, past the low stage carry.
    while (wr_cnt < 100) @(negedge clk);
    #1.3 rst_n = 1'b0;
    #1;
    check_reset_state("R8");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // Pass 3: must start again from address 0 and complete.
    repeat (6) @(negedge clk);
    chk(addr_oe == 1'b1 && cpu_be == 1'b0, "R8", "copier owns bus after restart",
        {addr_oe, cpu_be}, 2);
    wait_done("R8");
    chk(wr_cnt == COPY_LEN, "R8", "writes after restart", wr_cnt, COPY_LEN);
    check_full_image("R7");

    repeat (5) @(negedge clk);
    checks += mon_checks;
    fails  += mon_fails;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish actual=timeout expected=finish");
    checks += mon_checks;
    fails  += mon_fails;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule